// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block sits between a queue of thread-block launch requests and a small set of multiprocessor slots. Each request carries the number of threads in its block. The dispatcher places a block on a slot only when that slot can hold the whole block. A slot has room when both its resident-block count and its resident-thread count stay within their limits after the block is added. A block is never split across slots. When a slot reports that one of its blocks has finished, that block's thread count comes back with the report, and the slot's room grows by one block and by those threads.

The request side uses a valid/ready handshake. A request whose thread count can never be legal is consumed and flagged with a one-cycle error pulse. A legal request that fits nowhere is held off with ready low until a completion frees room. Each accepted legal request produces a one-cycle dispatch pulse on the next cycle, together with the chosen slot index. Blocks may finish in any order.

Top module: `blk_admit_top`

## Requirements
- R1: After reset every slot holds zero blocks and zero threads, and `disp_valid` and `req_err` are low.
- R2: A request with 0 threads, or with more than 512 threads (for example 513 or 1024), has `req_ready` high. On acceptance it produces `req_err` high for exactly the following cycle. It produces no dispatch and changes no slot's counts.
- R3: An accepted request of 1 to 512 threads produces `disp_valid` high for exactly the following cycle. `disp_slot` in that cycle carries the chosen slot index.
- R4: The chosen slot is the lowest-indexed slot that meets both capacity limits for the request's thread count.
- R5: A slot never holds more than 8 blocks. With 64-thread blocks, slot 0 takes 8 blocks (512 threads), and the ninth such block goes to slot 1.
- R6: A slot never holds more than 768 threads. Three 256-thread blocks fill slot 0, and a fourth goes to slot 1.
- R7: While a legal request fits no slot, `req_ready` is low and no dispatch occurs.
- R8: A completion pulse on `cmp_valid[s]`, with the block's size on slice s of `cmp_threads`, removes one block and that many threads from slot s at the clock edge. Admission sees the freed room from the next cycle on. A dispatch to the same slot in the same cycle is also applied, so both changes take effect at that edge.
- R9: Every dispatch goes to exactly one slot, and `disp_slot` is always below the number of slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request will be taken at this edge |
| req_threads | input | REQ_W (11) | Threads in the requested block |
| cmp_valid | input | NUM_SLOTS (2) | Per-slot completion pulse |
| cmp_threads | input | NUM_SLOTS*REQ_W (22) | Thread count of the finishing block, one slice per slot |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_slot | output | SLOT_W (1) | Slot that received the block |
| req_err | output | 1 | One-cycle pulse for a request that can never fit |

## Verification
The bench builds the block with its default values: two slots, 8 blocks and 768 threads per slot, and 512 threads per legal request. These values are small, so short sequences reach every limit. Nine 64-thread blocks show the block limit spilling into slot 1. Three 256-thread blocks fill a slot exactly. Under 512-thread requests both slots reach a full stall, where ready stays low. A long stretch of mixed requests and completions, including completions that land in the same cycle as a dispatch, is compared each clock against a behavioural model.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

  // True when a block of want threads can join a slot that now holds
  // blk blocks and thr threads, given both per-slot capacity limits.
  function automatic logic slot_fits(input int blk, input int thr, input int want,
                                     input int max_blk, input int max_thr);
    return (blk < max_blk) && ((thr + want) <= max_thr);
  endfunction

  // True when a thread count is a legal block size.
  function automatic logic size_legal(input int want, input int max_req);
    return (want >= 1) && (want <= max_req);
  endfunction

endpackage

// File: rtl/blk_admit_screen.sv
module blk_admit_screen #(
  parameter int REQ_W   = 11,
  parameter int MAX_REQ = 512
) (
  input  logic [REQ_W-1:0] req_threads,
  output logic             req_legal
);
  always_comb req_legal = blk_admit_pkg::size_legal(int'(req_threads), MAX_REQ);
endmodule

// File: rtl/blk_admit_ledger.sv
module blk_admit_ledger #(
  parameter int MAX_BLK = 8,
  parameter int MAX_THR = 768,
  parameter int REQ_W   = 11,
  parameter int BLK_W   = 4,
  parameter int THR_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [REQ_W-1:0] grant_thr,
  input  logic             done,
  input  logic [REQ_W-1:0] done_thr,
  input  logic [REQ_W-1:0] want_thr,
  output logic             fit,
  output logic [BLK_W-1:0] blk_cnt,
  output logic [THR_W-1:0] thr_cnt
);
  logic [BLK_W-1:0] blk_q;
  logic [THR_W-1:0] thr_q;
  logic [THR_W-1:0] thr_add, thr_sub;

  always_comb begin
    thr_add = grant ? THR_W'(grant_thr) : '0;
    thr_sub = done  ? THR_W'(done_thr)  : '0;
    fit     = blk_admit_pkg::slot_fits(int'(blk_q), int'(thr_q), int'(want_thr),
                                       MAX_BLK, MAX_THR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      thr_q <= '0;
    end else begin
      blk_q <= blk_q + BLK_W'(grant) - BLK_W'(done);
      thr_q <= thr_q + thr_add - thr_sub;
    end
  end

  assign blk_cnt = blk_q;
  assign thr_cnt = thr_q;
endmodule

// File: rtl/blk_admit_pick.sv
module blk_admit_pick #(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1
) (
  input  logic [NUM_SLOTS-1:0] fit_vec,
  output logic [NUM_SLOTS-1:0] pick_onehot,
  output logic [SLOT_W-1:0]    pick_idx,
  output logic                 pick_any
);
  always_comb begin
    pick_idx    = '0;
    pick_any    = 1'b0;
    pick_onehot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (fit_vec[i]) begin
        pick_idx = SLOT_W'(i);
        pick_any = 1'b1;
      end
    end
    if (pick_any) pick_onehot[pick_idx] = 1'b1;
  end
endmodule

// File: rtl/blk_admit_top.sv
module blk_admit_top #(
  parameter int NUM_SLOTS = 2,
  parameter int MAX_BLK   = 8,
  parameter int MAX_THR   = 768,
  parameter int MAX_REQ   = 512,
  parameter int REQ_W     = 11,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [REQ_W-1:0]           req_threads,
  input  logic [NUM_SLOTS-1:0]       cmp_valid,
  input  logic [NUM_SLOTS*REQ_W-1:0] cmp_threads,
  output logic                       disp_valid,
  output logic [SLOT_W-1:0]          disp_slot,
  output logic                       req_err
);
  localparam int BLK_W = $clog2(MAX_BLK + 1);
  localparam int THR_W = $clog2(MAX_THR + 1);

  logic                       req_legal;
  logic [NUM_SLOTS-1:0]       fit_vec, pick_onehot, grant_vec;
  logic [SLOT_W-1:0]          pick_idx;
  logic                       pick_any;
  logic                       accept, dispatch_fire, reject_fire;
  logic [NUM_SLOTS*BLK_W-1:0] blk_flat;
  logic [NUM_SLOTS*THR_W-1:0] thr_flat;

  blk_admit_screen #(.REQ_W(REQ_W), .MAX_REQ(MAX_REQ)) screen_i (
    .req_threads(req_threads),
    .req_legal  (req_legal)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    blk_admit_ledger #(
      .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .REQ_W(REQ_W),
      .BLK_W(BLK_W), .THR_W(THR_W)
    ) ledger_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (grant_vec[s]),
      .grant_thr(req_threads),
      .done     (cmp_valid[s]),
      .done_thr (cmp_threads[s*REQ_W +: REQ_W]),
      .want_thr (req_threads),
      .fit      (fit_vec[s]),
      .blk_cnt  (blk_flat[s*BLK_W +: BLK_W]),
      .thr_cnt  (thr_flat[s*THR_W +: THR_W])
    );
  end

  blk_admit_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) pick_i (
    .fit_vec    (fit_vec),
    .pick_onehot(pick_onehot),
    .pick_idx   (pick_idx),
    .pick_any   (pick_any)
  );

  always_comb begin
    req_ready     = !req_legal || pick_any;
    accept        = req_valid && req_ready;
    dispatch_fire = accept && req_legal;
    reject_fire   = accept && !req_legal;
    grant_vec     = dispatch_fire ? pick_onehot : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_slot  <= '0;
      req_err    <= 1'b0;
    end else begin
      disp_valid <= dispatch_fire;
      req_err    <= reject_fire;
      if (dispatch_fire) disp_slot <= pick_idx;
    end
  end
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int NUM_SLOTS = 2,
  parameter int MAX_BLK   = 8,
  parameter int MAX_THR   = 768,
  parameter int MAX_REQ   = 512,
  parameter int REQ_W     = 11,
  parameter int SLOT_W    = 1,
  parameter int BLK_W     = 4,
  parameter int THR_W     = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [REQ_W-1:0]           req_threads,
  input logic                       disp_valid,
  input logic [SLOT_W-1:0]          disp_slot,
  input logic                       req_err,
  input logic [NUM_SLOTS-1:0]       grant_vec,
  input logic [NUM_SLOTS*BLK_W-1:0] blk_flat,
  input logic [NUM_SLOTS*THR_W-1:0] thr_flat
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cap
    p_blk_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(blk_flat[g*BLK_W +: BLK_W]) <= MAX_BLK);
    p_thr_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_flat[g*THR_W +: THR_W]) <= MAX_THR);
  end

  p_bad_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_threads == '0 || int'(req_threads) > MAX_REQ))
    |=> (req_err && !disp_valid));

  p_good_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_threads != '0 && int'(req_threads) <= MAX_REQ)
    |=> (disp_valid && !req_err));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (grant_vec == '0));

  p_one_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_slot_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (int'(disp_slot) < NUM_SLOTS));
endmodule

bind blk_admit_top blk_admit_chk #(
  .NUM_SLOTS(NUM_SLOTS), .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .MAX_REQ(MAX_REQ),
  .REQ_W(REQ_W), .SLOT_W(SLOT_W), .BLK_W(BLK_W), .THR_W(THR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_threads(req_threads), .disp_valid(disp_valid), .disp_slot(disp_slot),
  .req_err(req_err), .grant_vec(grant_vec), .blk_flat(blk_flat), .thr_flat(thr_flat)
);

// File: tb/blk_admit_top_tb_top.sv
module blk_admit_top_tb_top;
  localparam int NS     = 2;
  localparam int MAXB   = 8;
  localparam int MAXT   = 768;
  localparam int MAXR   = 512;
  localparam int RW     = 11;
  localparam int SW     = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [RW-1:0]     req_threads = '0;
  logic [NS-1:0]     cmp_valid = '0;
  logic [NS*RW-1:0]  cmp_threads = '0;
  logic              disp_valid;
  logic [SW-1:0]     disp_slot;
  logic              req_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // behavioural model state
  int mb [NS];
  int mt [NS];
  int mq [NS][$];
  bit exp_dv  = 0;
  bit exp_err = 0;
  int exp_slot = 0;

  always #10 clk = ~clk;

  blk_admit_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .cmp_valid(cmp_valid), .cmp_threads(cmp_threads),
    .disp_valid(disp_valid), .disp_slot(disp_slot), .req_err(req_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input int t);
    for (int s = 0; s < NS; s++)
      if (mb[s] < MAXB && mt[s] + t <= MAXT) return s;
    return -1;
  endfunction

  function automatic bit model_legal(input int t);
    return t >= 1 && t <= MAXR;
  endfunction

  // per-clock comparison against the model, then model advance
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        mb[s] = 0; mt[s] = 0; mq[s].delete();
      end
      exp_dv = 0; exp_err = 0; exp_slot = 0;
    end else begin
      int t, p;
      bit rdy, acc;
      chk(disp_valid == exp_dv, "R3 disp_valid", int'(disp_valid), int'(exp_dv));
      chk(req_err == exp_err, "R2 req_err", int'(req_err), int'(exp_err));
      if (exp_dv) begin
        chk(int'(disp_slot) == exp_slot, "R4 disp_slot", int'(disp_slot), exp_slot);
        chk(int'(disp_slot) < NS, "R9 slot range", int'(disp_slot), NS - 1);
      end
      t = int'(req_threads);
      p = model_pick(t);
      rdy = !model_legal(t) || (p >= 0);
      chk(req_ready == rdy, "R7 R4 req_ready", int'(req_ready), int'(rdy));
      acc = req_valid && rdy;
      exp_dv  = acc && model_legal(t);
      exp_err = acc && !model_legal(t);
      if (exp_dv) begin
        exp_slot = p;
        mb[p]++; mt[p] += t; mq[p].push_back(t);
      end
      for (int s = 0; s < NS; s++) begin
        if (cmp_valid[s] && mq[s].size() > 0) begin
          int f;
          f = mq[s].pop_front();
          mb[s]--; mt[s] -= f;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic send(input int t);
    @(posedge clk); #1;
    req_valid = 1'b1; req_threads = RW'(t);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_blk(input int s);
    @(posedge clk); #1;
    cmp_valid[s] = 1'b1;
    cmp_threads[s*RW +: RW] = RW'(mq[s][0]);
    @(posedge clk); #1;
    cmp_valid = '0;
  endtask

  task automatic drain();
    for (int s = 0; s < NS; s++)
      while (mq[s].size() > 0) finish_blk(s);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    req_threads = RW'(64);
    @(negedge clk);
    // R1: reset state
    chk(!disp_valid && !req_err, "R1 outputs idle", int'(disp_valid | req_err), 0);
    chk(req_ready, "R1 empty slots ready", int'(req_ready), 1);

    // R2: illegal sizes
    send(0);    @(negedge clk); chk(req_err && !disp_valid, "R2 zero rejected", int'(req_err), 1);
    send(1024); @(negedge clk); chk(req_err && !disp_valid, "R2 1024 rejected", int'(req_err), 1);
    send(513);  @(negedge clk); chk(req_err, "R2 513 rejected", int'(req_err), 1);
    @(negedge clk); chk(!req_err, "R2 single pulse", int'(req_err), 0);

    // R5: block limit binds with 64-thread blocks
    for (int i = 0; i < 8; i++) begin
      send(64); @(negedge clk);
      chk(disp_valid && disp_slot == 0, "R5 slot0 fill", int'(disp_slot), 0);
    end
    send(64); @(negedge clk);
    chk(disp_valid && disp_slot == 1, "R5 ninth block to slot1", int'(disp_slot), 1);
    for (int i = 0; i < 7; i++) send(64);

    // R7: all slots at the block limit
    @(posedge clk); #1 req_valid = 1'b1; req_threads = RW'(1);
    repeat (3) begin
      @(negedge clk);
      chk(!req_ready && !disp_valid, "R7 stall when full", int'(req_ready), 0);
    end
    // R8: completion frees room from the next cycle
    @(posedge clk); #1 cmp_valid[1] = 1'b1; cmp_threads[RW +: RW] = RW'(64);
    @(negedge clk); chk(!req_ready, "R8 room not yet visible", int'(req_ready), 0);
    @(posedge clk); #1 cmp_valid = '0;
    @(negedge clk); chk(req_ready, "R8 room visible next cycle", int'(req_ready), 1);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk); chk(disp_valid && disp_slot == 1, "R8 refill slot1", int'(disp_slot), 1);
    drain();

    // R6: thread limit binds with 256-thread blocks
    for (int i = 0; i < 3; i++) begin
      send(256); @(negedge clk);
      chk(disp_slot == 0, "R6 slot0 takes three", int'(disp_slot), 0);
    end
    send(256); @(negedge clk);
    chk(disp_valid && disp_slot == 1, "R6 fourth to slot1", int'(disp_slot), 1);
    send(512); @(negedge clk);
    chk(disp_slot == 1, "R4 512 fits slot1", int'(disp_slot), 1);

    // R8: dispatch and completion on the same slot in one cycle
    finish_blk(0);
    @(posedge clk); #1;
    req_valid = 1'b1; req_threads = RW'(100);
    cmp_valid[0] = 1'b1; cmp_threads[0 +: RW] = RW'(256);
    @(posedge clk); #1;
    req_valid = 1'b0; cmp_valid = '0; req_threads = RW'(412);
    @(negedge clk);
    chk(disp_valid && disp_slot == 0, "R8 same-cycle dispatch", int'(disp_slot), 0);
    chk(req_ready, "R8 both applied, 412 fits", int'(req_ready), 1);
    req_threads = RW'(413);
    @(negedge clk);
    chk(!req_ready, "R8 both applied, 413 stalls", int'(req_ready), 0);
    drain();

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      req_valid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 9))
        0:       req_threads = RW'($urandom_range(0, 1100));
        1, 2:    req_threads = RW'(64);
        3, 4:    req_threads = RW'(256);
        5:       req_threads = RW'(512);
        default: req_threads = RW'($urandom_range(1, 512));
      endcase
      for (int s = 0; s < NS; s++) begin
        if (mq[s].size() > 0 && $urandom_range(0, 3) == 0) begin
          cmp_valid[s] = 1'b1;
          cmp_threads[s*RW +: RW] = RW'(mq[s][0]);
        end else begin
          cmp_valid[s] = 1'b0;
        end
      end
    end
    @(posedge clk); #1 req_valid = 1'b0; cmp_valid = '0;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule